// File: doc/BRIEF.md
# Exception Entry and Banked Register Switch

This block owns the live copies of two general registers (r29 and r30) and the saved status word. It also keeps a private copy of those three values for each privilege bank. A bank switch has two triggers. One is a direct mode-switch request. The other is an exception accepted on a small valid/ready stream. On a switch, the live values are parked in the bank of the outgoing mode and the incoming bank's values become live.

Exception entry does the following in a single clock edge:
- picks the target mode and the vector from the cause code;
- relocates the vector high when the high-vector control bit is set;
- performs the bank switch;
- saves the pre-exception status word;
- builds the new status word, with the new mode and interrupts masked;
- captures the program counter into r30.

One cycle later the block raises a done pulse. The pulse carries the redirect address for the fetch unit to flush to.

The exception stream obeys these rules:
- A request is accepted on a rising edge where `exc_valid` and `exc_ready` are both high.
- `exc_ready` drops for exactly the cycle in which `exc_done` is high. The requester must hold `exc_valid` and `exc_cause` steady until it sees acceptance.
- At most one exception can be accepted every two cycles.

Top module: `exc_bank_unit`

## Requirements
- R1: Mode codes sit in bits [4:0] of the status word. User (0x10) and super-user (0x1F) share bank 0. Privileged (0x13) uses bank 1, trap (0x17) bank 2, extension (0x1B) bank 3 and interrupt (0x12) bank 4.
- R2: When `msw_req` is high and no exception is accepted on that edge, a change of bank has two effects. The live r29, r30 and saved status are written into the bank of the current mode, which is taken from `stat_in[4:0]`. The values held in the bank of `msw_mode` become live the cycle after the edge.
- R3: When the old and new modes map to the same bank, no value is saved or loaded. This applies to both a mode switch and an exception.
- R4: Cause 0 enters privileged mode at vector 0x08. Cause 1 (instruction fetch abort) enters trap mode at 0x0C. Cause 2 (data abort) enters trap mode at 0x10. Cause 3 (interrupt) enters interrupt mode at 0x18.
- R5: With `hi_vec` high at acceptance, 0xFFFF0000 is added to the vector.
- R6: On exception entry, after the bank switch, the saved status receives `stat_in`. `new_stat` equals `stat_in` with bits [4:0] replaced by the target mode and bit 7 (interrupt disable) set.
- R7: On exception entry, r30 receives `pc_in` and `redirect_pc` receives the vector.
- R8: `exc_done` is high for exactly one cycle, in the cycle after acceptance. `exc_ready` is low during that cycle and high otherwise.
- R9: An accepted exception with cause 4 to 7 raises `err` for one cycle in the next cycle, with no done and no change of any register. So does an exception or mode switch whose current or target mode code is not listed in R1.
- R10: `gw_en` writes `gw_data` into r29 (`gw_sel`=0), r30 (1) or the saved status (2). Select 3 is ignored. The write takes effect only on an edge with no accepted exception and no mode-switch request.
- R11: After reset, all live and banked values, `exc_done`, `err`, `redirect_pc` and `new_stat` are zero, and `exc_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_valid | input | 1 | Exception request valid |
| exc_ready | output | 1 | Exception request can be accepted |
| exc_cause | input | 3 | Exception cause code |
| hi_vec | input | 1 | High-vector relocation control bit |
| pc_in | input | 32 | Current program counter |
| stat_in | input | 32 | Current status word (mode in bits [4:0]) |
| msw_req | input | 1 | Mode switch request |
| msw_mode | input | 5 | Target mode of the switch |
| gw_en | input | 1 | Live register write enable |
| gw_sel | input | 2 | Live register write select |
| gw_data | input | 32 | Live register write data |
| r29_q | output | 32 | Live r29 |
| r30_q | output | 32 | Live r30 |
| bsr_q | output | 32 | Live saved status word |
| exc_done | output | 1 | One-cycle exception entry pulse |
| redirect_pc | output | 32 | Vector to fetch from |
| new_stat | output | 32 | Status word to install |
| err | output | 1 | One-cycle invalid request pulse |

## Verification
The assertions assume two things about `stat_in`. It must reflect the mode installed by the last switch or exception. It must also stay unchanged across the edge that accepts a request. They further assume that `exc_valid` with its cause is held until acceptance.

The stimulus respects these assumptions. It keeps a status variable, drives it onto `stat_in`, and updates it only in the cycle after a switch completes. It raises requests only on falling edges, and it waits for `exc_ready` before presenting an exception.

// File: rtl/exc_bank_pkg.sv
package exc_bank_pkg;
  localparam int NUM_BANKS = 5;
  localparam int BANK_W    = $clog2(NUM_BANKS);
  localparam int MODE_W    = 5;
  localparam int IRQ_OFF_BIT = 7;

  typedef enum logic [MODE_W-1:0] {
    M_USER = 5'h10,
    M_INTR = 5'h12,
    M_PRIV = 5'h13,
    M_TRAP = 5'h17,
    M_EXTN = 5'h1B,
    M_SUSR = 5'h1F
  } cpu_mode_e;

  typedef enum logic [2:0] {
    C_PRIV = 3'd0,
    C_IABT = 3'd1,
    C_DABT = 3'd2,
    C_IRQ  = 3'd3
  } exc_cause_e;
endpackage

// File: rtl/mode_bank_map.sv
module mode_bank_map
  import exc_bank_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output logic [BANK_W-1:0] bank,
  output logic              known
);
  always_comb begin
    known = 1'b1;
    bank  = '0;
    case (mode)
      M_USER, M_SUSR: bank = BANK_W'(0);
      M_PRIV:         bank = BANK_W'(1);
      M_TRAP:         bank = BANK_W'(2);
      M_EXTN:         bank = BANK_W'(3);
      M_INTR:         bank = BANK_W'(4);
      default:        known = 1'b0;
    endcase
  end
endmodule

// File: rtl/vector_sel.sv
module vector_sel
  import exc_bank_pkg::*;
#(
  parameter int          XLEN    = 32,
  parameter logic [31:0] HI_BASE = 32'hFFFF_0000
) (
  input  logic [2:0]        cause,
  input  logic              hi_vec,
  output logic [MODE_W-1:0] tgt_mode,
  output logic [XLEN-1:0]   vector,
  output logic              known
);
  logic [7:0] offset;

  always_comb begin
    known    = 1'b1;
    tgt_mode = M_PRIV;
    offset   = 8'h00;
    case (cause)
      C_PRIV: begin tgt_mode = M_PRIV; offset = 8'h08; end
      C_IABT: begin tgt_mode = M_TRAP; offset = 8'h0C; end
      C_DABT: begin tgt_mode = M_TRAP; offset = 8'h10; end
      C_IRQ:  begin tgt_mode = M_INTR; offset = 8'h18; end
      default: known = 1'b0;
    endcase
    vector = XLEN'(offset) + (hi_vec ? XLEN'(HI_BASE) : '0);
  end
endmodule

// File: rtl/bank_file.sv
module bank_file #(
  parameter int W      = 32,
  parameter int NB     = 5,
  localparam int SEL_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] wr_bank,
  input  logic [W-1:0]     wr_r29,
  input  logic [W-1:0]     wr_r30,
  input  logic [W-1:0]     wr_bsr,
  input  logic [SEL_W-1:0] rd_bank,
  output logic [W-1:0]     rd_r29,
  output logic [W-1:0]     rd_r30,
  output logic [W-1:0]     rd_bsr
);
  logic [W-1:0] r29_m [NB];
  logic [W-1:0] r30_m [NB];
  logic [W-1:0] bsr_m [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r29_m[b] <= '0;
        r30_m[b] <= '0;
        bsr_m[b] <= '0;
      end else if (we && (wr_bank == SEL_W'(b))) begin
        r29_m[b] <= wr_r29;
        r30_m[b] <= wr_r30;
        bsr_m[b] <= wr_bsr;
      end
    end
  end

  always_comb begin
    rd_r29 = '0;
    rd_r30 = '0;
    rd_bsr = '0;
    for (int b = 0; b < NB; b++) begin
      if (rd_bank == SEL_W'(b)) begin
        rd_r29 = r29_m[b];
        rd_r30 = r30_m[b];
        rd_bsr = bsr_m[b];
      end
    end
  end
endmodule

// File: rtl/exc_bank_unit.sv
module exc_bank_unit
  import exc_bank_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exc_valid,
  output logic            exc_ready,
  input  logic [2:0]      exc_cause,
  input  logic            hi_vec,
  input  logic [XLEN-1:0] pc_in,
  input  logic [XLEN-1:0] stat_in,
  input  logic            msw_req,
  input  logic [4:0]      msw_mode,
  input  logic            gw_en,
  input  logic [1:0]      gw_sel,
  input  logic [XLEN-1:0] gw_data,
  output logic [XLEN-1:0] r29_q,
  output logic [XLEN-1:0] r30_q,
  output logic [XLEN-1:0] bsr_q,
  output logic            exc_done,
  output logic [XLEN-1:0] redirect_pc,
  output logic [XLEN-1:0] new_stat,
  output logic            err
);
  logic              exc_acc, exc_ok, sw_act, sw_ok, swap;
  logic [MODE_W-1:0] cur_mode, vec_mode, tgt_mode;
  logic [BANK_W-1:0] old_bank, new_bank;
  logic              old_known, new_known, cause_known;
  logic [XLEN-1:0]   vec_addr, b_r29, b_r30, b_bsr, stat_next;

  assign exc_acc  = exc_valid && exc_ready;
  assign cur_mode = stat_in[MODE_W-1:0];

  vector_sel #(.XLEN(XLEN)) u_vec (
    .cause(exc_cause), .hi_vec(hi_vec),
    .tgt_mode(vec_mode), .vector(vec_addr), .known(cause_known)
  );

  assign tgt_mode = exc_acc ? vec_mode : msw_mode;

  mode_bank_map u_old (.mode(cur_mode), .bank(old_bank), .known(old_known));
  mode_bank_map u_new (.mode(tgt_mode), .bank(new_bank), .known(new_known));

  assign exc_ok = exc_acc && cause_known && old_known;
  assign sw_act = !exc_acc && msw_req;
  assign sw_ok  = sw_act && old_known && new_known;
  assign swap   = (exc_ok || sw_ok) && (old_bank != new_bank);

  bank_file #(.W(XLEN), .NB(NUM_BANKS)) u_banks (
    .clk(clk), .rst_n(rst_n),
    .we(swap), .wr_bank(old_bank),
    .wr_r29(r29_q), .wr_r30(r30_q), .wr_bsr(bsr_q),
    .rd_bank(new_bank),
    .rd_r29(b_r29), .rd_r30(b_r30), .rd_bsr(b_bsr)
  );

  always_comb begin
    stat_next = stat_in;
    stat_next[MODE_W-1:0]   = vec_mode;
    stat_next[IRQ_OFF_BIT]  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r29_q       <= '0;
      r30_q       <= '0;
      bsr_q       <= '0;
      exc_done    <= 1'b0;
      exc_ready   <= 1'b1;
      err         <= 1'b0;
      redirect_pc <= '0;
      new_stat    <= '0;
    end else begin
      exc_done  <= exc_ok;
      exc_ready <= !exc_ok;
      err       <= (exc_acc && !exc_ok) || (sw_act && !sw_ok);
      if (exc_ok) begin
        if (swap) r29_q <= b_r29;
        r30_q       <= pc_in;
        bsr_q       <= stat_in;
        redirect_pc <= vec_addr;
        new_stat    <= stat_next;
      end else if (sw_ok) begin
        if (swap) begin
          r29_q <= b_r29;
          r30_q <= b_r30;
          bsr_q <= b_bsr;
        end
      end else if (!exc_acc && !msw_req && gw_en) begin
        case (gw_sel)
          2'd0:    r29_q <= gw_data;
          2'd1:    r30_q <= gw_data;
          2'd2:    bsr_q <= gw_data;
          default: ;
        endcase
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_done |=> !exc_done); // R8
  AST_READY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    exc_done |-> !exc_ready); // R8
  AST_BAD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_ready && exc_cause > 3'd3) |=> (err && !exc_done)); // R9
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($stable(r29_q) && $stable(r30_q) && $stable(bsr_q))); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    exc_done |-> new_stat[IRQ_OFF_BIT]); // R6
  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_done |-> (redirect_pc[XLEN-1:16] == '0 || &redirect_pc[XLEN-1:16])); // R5
  AST_RET_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    exc_ok |=> (r30_q == $past(pc_in))); // R7
endmodule

// File: tb/exc_bank_unit_test.sv
module exc_bank_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        exc_valid = 0, hi_vec = 0, msw_req = 0, gw_en = 0;
  logic [2:0]  exc_cause = 0;
  logic [31:0] pc_in = 0, stat_in = 32'h10, gw_data = 0;
  logic [4:0]  msw_mode = 0;
  logic [1:0]  gw_sel = 0;
  logic        exc_ready, exc_done, err;
  logic [31:0] r29_q, r30_q, bsr_q, redirect_pc, new_stat;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_bank_unit uut (.*);

  typedef struct packed {
    logic        is_err;
    logic [31:0] pc, st, r29, r30, bsr;
  } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];

  int checks = 0, fails = 0;
  bit over = 0;

  logic [31:0] m29, m30, mbsr;
  logic [31:0] k29 [5], k30 [5], kbsr [5];

  function automatic int bank_of(input logic [4:0] m);
    case (m)
      5'h10, 5'h1F: return 0;
      5'h13: return 1;
      5'h17: return 2;
      5'h1B: return 3;
      5'h12: return 4;
      default: return -1;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    over = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // monitor: pops expected items as done/err pulses appear
  always @(negedge clk) begin
    if (rst_n && (exc_done || err)) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R8 actual=unexpected pulse expected=none");
      end else begin
        exp_t e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        if (e.is_err) begin
          if (!err || exc_done || r29_q !== e.r29 || r30_q !== e.r30 || bsr_q !== e.bsr) begin
            fails++;
            $display("FAIL %s actual=err%0b done%0b %h %h %h expected=err1 done0 %h %h %h",
                     t, err, exc_done, r29_q, r30_q, bsr_q, e.r29, e.r30, e.bsr);
          end
        end else if (!exc_done || redirect_pc !== e.pc || new_stat !== e.st ||
                     r29_q !== e.r29 || r30_q !== e.r30 || bsr_q !== e.bsr) begin
          fails++;
          $display("FAIL %s actual=%h %h %h %h %h expected=%h %h %h %h %h", t,
                   redirect_pc, new_stat, r29_q, r30_q, bsr_q,
                   e.pc, e.st, e.r29, e.r30, e.bsr);
        end
      end
    end
  end

  task automatic do_exc(input logic [2:0] cause, input logic hv, input logic [31:0] pc, input string tag);
    exp_t e;
    int ob, nb;
    logic [4:0] nm;
    logic [31:0] vec;
    while (!exc_ready) @(negedge clk);
    exc_valid = 1; exc_cause = cause; hi_vec = hv; pc_in = pc;
    case (cause)
      3'd0: begin nm = 5'h13; vec = 32'h08; end
      3'd1: begin nm = 5'h17; vec = 32'h0C; end
      3'd2: begin nm = 5'h17; vec = 32'h10; end
      3'd3: begin nm = 5'h12; vec = 32'h18; end
      default: begin nm = 5'h00; vec = 32'h0; end
    endcase
    if (hv) vec = vec + 32'hFFFF_0000;
    ob = bank_of(stat_in[4:0]);
    if (cause > 3 || ob < 0) begin
      e = '{1'b1, 32'h0, 32'h0, m29, m30, mbsr};
      exp_q.push_back(e); tag_q.push_back("R9");
      @(negedge clk);
      exc_valid = 0;
    end else begin
      nb = bank_of(nm);
      if (ob != nb) begin
        k29[ob] = m29; k30[ob] = m30; kbsr[ob] = mbsr;
        m29 = k29[nb];
      end
      m30 = pc; mbsr = stat_in;
      e.is_err = 0; e.pc = vec;
      e.st = {stat_in[31:8], 1'b1, stat_in[6:5], nm};
      e.r29 = m29; e.r30 = m30; e.bsr = mbsr;
      exp_q.push_back(e); tag_q.push_back(tag);
      @(negedge clk);
      exc_valid = 0;
      chk("R8 ready low during done", {31'b0, exc_ready}, 32'd0);
      stat_in = e.st;
      @(negedge clk);
      chk("R8 done single cycle", {31'b0, exc_done}, 32'd0);
    end
  endtask

  task automatic do_msw(input logic [4:0] m, input string tag);
    int ob, nb;
    ob = bank_of(stat_in[4:0]); nb = bank_of(m);
    msw_req = 1; msw_mode = m;
    if (ob < 0 || nb < 0) begin
      exp_q.push_back('{1'b1, 32'h0, 32'h0, m29, m30, mbsr});
      tag_q.push_back("R9");
      @(negedge clk);
      msw_req = 0;
    end else begin
      if (ob != nb) begin
        k29[ob] = m29; k30[ob] = m30; kbsr[ob] = mbsr;
        m29 = k29[nb]; m30 = k30[nb]; mbsr = kbsr[nb];
      end
      @(negedge clk);
      msw_req = 0;
      chk({tag, " r29"}, r29_q, m29);
      chk({tag, " r30"}, r30_q, m30);
      chk({tag, " bsr"}, bsr_q, mbsr);
      stat_in = {stat_in[31:5], m};
    end
  endtask

  task automatic do_wr(input logic [1:0] sel, input logic [31:0] d);
    gw_en = 1; gw_sel = sel; gw_data = d;
    @(negedge clk);
    gw_en = 0;
    case (sel)
      2'd0: m29 = d;
      2'd1: m30 = d;
      2'd2: mbsr = d;
      default: ;
    endcase
    chk("R10 r29", r29_q, m29);
    chk("R10 r30", r30_q, m30);
    chk("R10 bsr", bsr_q, mbsr);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!over) begin
      fails++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    m29 = 0; m30 = 0; mbsr = 0;
    for (int i = 0; i < 5; i++) begin k29[i] = 0; k30[i] = 0; kbsr[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 r29", r29_q, 0);
    chk("R11 r30", r30_q, 0);
    chk("R11 bsr", bsr_q, 0);
    chk("R11 ready/done/err", {29'b0, exc_ready, exc_done, err}, 32'h4);
    chk("R11 redirect", redirect_pc, 0);

    stat_in = 32'h0000_0010;
    do_wr(2'd0, 32'hA1A1_0001);
    do_wr(2'd1, 32'hA2A2_0002);
    do_wr(2'd2, 32'hA3A3_0003);
    do_wr(2'd3, 32'hDEAD_BEEF);                       // R10 select 3 ignored

    do_exc(3'd3, 1'b0, 32'h0000_4000, "R4 irq R7");    // user -> intr
    do_wr(2'd0, 32'hB1B1_0011);
    do_msw(5'h13, "R2 intr->priv");
    do_exc(3'd1, 1'b1, 32'h0000_5004, "R5 iabt high");  // priv -> trap
    do_wr(2'd0, 32'hC1C1_0021);
    do_exc(3'd2, 1'b0, 32'h0000_6008, "R3 dabt same bank R6");
    do_msw(5'h12, "R2 restore intr");
    do_exc(3'd0, 1'b1, 32'h0000_700C, "R4 priv high R1");
    do_exc(3'd6, 1'b0, 32'h0000_8000, "R9");
    @(negedge clk);
    do_msw(5'h05, "R9");
    @(negedge clk);
    do_msw(5'h10, "R1 to user");
    do_wr(2'd1, 32'hE2E2_0044);
    do_msw(5'h1F, "R3 user->susr");
    do_msw(5'h1B, "R1 to extn");
    do_msw(5'h1F, "R2 extn->susr");
    do_exc(3'd3, 1'b1, 32'h0000_9010, "R6 irq from susr");
    repeat (2) @(negedge clk);
    chk("R8 queue drained", exp_q.size(), 0);
    finish_run();
  end
endmodule